// File: doc/BRIEF.md
# Push-Button Debouncer with Input Synchronizer

This block turns one raw mechanical push-button level into a clean, registered level. The raw pin is asynchronous and can chatter between 0 and 1 many times before it settles. The block first passes the pin through a short flip-flop synchronizer, so the rest of the logic only sees values captured on rising clock edges. It then compares the synchronized level with the clean level it currently drives. It changes the clean level only after the two have disagreed on every cycle of an unbroken run of 2^N cycles.

A run counter advances on each cycle of disagreement. It returns to zero on any cycle where the synchronized level matches the clean output, so a bounce back to the old level restarts the whole window. When the run reaches its full length, the clean output takes the synchronized value and the counter clears. Presses and releases are filtered the same way. A released button reads 0 and a pressed button reads 1. Choose N so that 2^N clock periods last a few milliseconds at the system clock rate.

Top module: `btn_debounce`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the clean output reads 0 (released) on the next edge, and the settling window restarts from zero.
- R2: The raw input is seen only through a two-stage synchronizer. A raw level that is captured at edge k and then held appears on the clean output at edge k+1+2^N.
- R3: Any cycle on which the synchronized level equals the clean output clears the run, so a bounce back restarts the full 2^N-cycle window.
- R4: A release (a change from 1 to 0) is filtered with the same window and the same latency as a press.
- R5: A bounce burst in which the raw level never stays opposite to the clean output for 2^N consecutive synchronized cycles leaves the clean output unchanged.
- R6: The clean output changes only on an edge where the synchronized level has differed from it for the full window.
- R7: The run counter never wraps. It clears on the cycle it commits a change.
- R8: On a commit, the clean output takes the synchronized level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Raw asynchronous push-button level, 1 = pressed |
| btn_clean | output | 1 | Debounced, registered button level, 1 = pressed |

## Verification
A wrong internal state shows up only as btn_clean changing at the wrong edge. Suppose the run counter fails to clear on a bounce back. Then a chattering press commits early, and the first bad edge can come within 2^N cycles of the first bounce. An off-by-one in the terminal count or in the synchronizer depth moves every commit by exactly one cycle. A reference model that is compared on every clock catches this on the first settled press. A commit that latches the wrong value leaves the output stuck, and the next compare after the commit exposes it.

// File: rtl/btn_debounce_pkg.sv
package btn_debounce_pkg;

  // Number of consecutive disagreeing cycles needed for a commit.
  function automatic int unsigned window_cycles(input int unsigned log2_len);
    return 32'd1 << log2_len;
  endfunction

  // Next value of the disagreement run counter.
  function automatic logic [31:0] run_next(input logic [31:0] cur,
                                           input logic differ,
                                           input logic at_end);
    if (!differ || at_end) return '0;
    return cur + 32'd1;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/btn_run_counter.sv
module btn_run_counter
  import btn_debounce_pkg::*;
#(
  parameter int N = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic differ,
  output logic commit
);
  localparam logic [N-1:0] TERM = N'(window_cycles(N) - 1);

  logic [N-1:0] run_q;
  logic         at_end;
  logic [31:0]  run_d;

  assign at_end = (run_q == TERM);
  assign commit = differ && at_end;
  assign run_d  = run_next(32'(run_q), differ, at_end);

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_d[N-1:0];
  end

  // R3
  match_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    !differ |=> run_q == '0);

  // R7
  commit_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> run_q == '0);

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (differ && !at_end) |=> run_q == $past(run_q) + 1'b1);
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int N           = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_clean
);
  logic synced;
  logic differ;
  logic commit;
  logic clean_q;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (btn_raw),
    .dout(synced)
  );

  assign differ = (synced != clean_q);

  btn_run_counter #(.N(N)) u_run (
    .clk   (clk),
    .rst   (rst),
    .differ(differ),
    .commit(commit)
  );

  always_ff @(posedge clk) begin
    if (rst)         clean_q <= 1'b0;
    else if (commit) clean_q <= synced;
  end

  assign btn_clean = clean_q;

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> !btn_clean);

  // R6
  change_needs_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_clean != $past(btn_clean)) |-> $past(commit));

  // R8
  commit_value_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> btn_clean == $past(synced));
endmodule

// File: tb/btn_debounce_test.sv
module btn_debounce_test;
  localparam int N   = 3;
  localparam int WIN = 1 << N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic btn_clean;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference state
  int ref_p1 = 0, ref_p2 = 0, ref_clean = 0, ref_streak = 0;

  always #5 clk = ~clk;

  btn_debounce #(.N(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .btn_clean(btn_clean)
  );

  always @(posedge clk) begin
    if (rst) begin
      ref_p1 = 0; ref_p2 = 0; ref_clean = 0; ref_streak = 0;
    end else begin
      if (ref_p2 != ref_clean) begin
        ref_streak = ref_streak + 1;
        if (ref_streak == WIN) begin
          ref_clean = ref_p2;
          ref_streak = 0;
        end
      end else begin
        ref_streak = 0;
      end
      ref_p2 = ref_p1;
      ref_p1 = int'(btn_raw);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input logic v);
    @(negedge clk);
    compared++;
    if (int'(btn_clean) != ref_clean) begin
      mismatched++;
      $display("FAIL %s: btn_clean actual %0d expected %0d at cycle %0d",
               tag, btn_clean, ref_clean, cycles);
    end
    btn_raw = v;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) step(v);
  endtask

  task automatic chatter(input int pairs, input int hi_len);
    for (int i = 0; i < pairs; i++) begin
      hold(1'b1, hi_len);
      hold(1'b0, 1);
    end
  endtask

  task automatic chatter_low(input int pairs, input int lo_len);
    for (int i = 0; i < pairs; i++) begin
      hold(1'b0, lo_len);
      hold(1'b1, 1);
    end
  endtask

  initial begin
    // R1: output released during and after reset
    tag = "R1";
    hold(1'b1, 4);
    @(negedge clk); rst = 1'b0; btn_raw = 1'b0;
    hold(1'b0, 5);

    // R5: bursts shorter than the window never commit
    tag = "R5";
    chatter(6, WIN - 2);
    hold(1'b0, WIN + 4);

    // R3: a bounce one cycle before the end restarts the window
    tag = "R3";
    hold(1'b1, WIN - 1);
    hold(1'b0, 1);
    hold(1'b1, WIN - 1);
    hold(1'b0, WIN + 4);

    // R2: a clean press commits after sync plus a full window
    tag = "R2";
    hold(1'b1, WIN + 6);

    // R6: a long hold changes nothing further
    tag = "R6";
    hold(1'b1, 3 * WIN);

    // R4: a bouncing release, then a settled release
    tag = "R4";
    chatter_low(5, WIN - 3);
    hold(1'b0, WIN + 6);

    // R8: exactly the window length of press, then a press of one less
    tag = "R8";
    hold(1'b1, WIN);
    hold(1'b0, WIN + 6);
    hold(1'b1, WIN - 1);
    hold(1'b0, WIN + 6);

    // R7: consecutive back-to-back settled changes
    tag = "R7";
    hold(1'b1, WIN + 3);
    hold(1'b0, WIN + 3);
    hold(1'b1, WIN + 3);

    // R1: reset in the middle of a pending release
    tag = "R1";
    hold(1'b0, WIN / 2);
    @(negedge clk); rst = 1'b1;
    hold(1'b0, 2);
    @(negedge clk); rst = 1'b0;
    hold(1'b1, WIN + 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule